// File: doc/BRIEF.md
# CAN Error Flag and Code Capture

This block sits beside a CAN protocol engine and turns its single-cycle error event pulses into sticky state that a host can inspect. Seven status events (bus lock, overload frame, receive overrun, recovery from bus-off, entry into bus-off, error-passive, error-warning) each set one bit of an eight-bit flag register. Seven bus-error detail events (ACK delimiter, dominant bit, recessive bit, CRC, ACK, form, stuff) are captured in a code store. Any captured detail also raises the summary bus-error flag.

The code store runs in one of two modes chosen by its top bit. In accumulating mode, new detail codes are ORed into the stored ones. In latest-only mode, each new bus error replaces the stored codes. The host clears flags and codes by writing a byte with 0 in each position to clear and 1 everywhere else. An enable register with the same layout as the flags masks a single level-sensitive interrupt request. The transmit and receive error counts are supplied from outside and can only be read through the byte bus.

Top module: `can_err_capture`

## Requirements
- R1: After reset, the flag register, the enable register, the code store (mode bit included) and the interrupt request are all 0.
- R2: A pulse on ev_status sets its flag bit on the next clock edge, and the bit stays set until the host clears it. The mapping is ev_status[6] to flag bit 7 (bus lock), [5] to bit 6 (overload), [4] to bit 5 (receive overrun), [3] to bit 4 (bus-off recovery), [2] to bit 3 (bus-off entry), [1] to bit 2 (error passive) and [0] to bit 1 (error warning).
- R3: A write to address 0 (flags) clears every flag bit written as 0 and leaves every bit written as 1 unchanged. A write never sets a flag.
- R4: When an event and a host clear hit the same flag or code bit in the same cycle, the bit ends up set.
- R5: Any nonzero ev_code sets flag bit 0 (bus error) on the next edge.
- R6: The code store keeps ev_code[6:0] in code bits 6..0. In order from bit 6 down to bit 0 these are ACK delimiter, dominant bit, recessive bit, CRC, ACK, form and stuff error.
- R7: With code bit 7 = 1 (accumulate), a new ev_code is ORed into the stored code bits.
- R8: With code bit 7 = 0 (latest-only), a nonzero ev_code replaces all seven stored code bits.
- R9: A write to address 2 loads wdata[7] into the mode bit and clears each code bit whose wdata bit is 0. The mode in force during a cycle is the stored one.
- R10: irq is 1 exactly when some flag bit and the matching enable bit are both 1. The enable register is at address 1, uses the flag layout, and is plain read/write. irq follows the registers in the same cycle.
- R11: reg_rdata shows, without delay, the flags at address 0, the enables at 1, the code store at 2, tx_err_cnt at 3 and rx_err_cnt at 4. Any other address reads 0.
- R12: Writes to address 3, to address 4 or to any unmapped address change no flag, enable or code bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_status | input | 7 | Status event pulses, mapped as in R2 |
| ev_code | input | 7 | Bus-error detail pulses, mapped as in R6 |
| tx_err_cnt | input | 8 | Transmit error count, read-only through the bus |
| rx_err_cnt | input | 8 | Receive error count, read-only through the bus |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| flag_q | output | 8 | Error flag register |
| code_q | output | 8 | Code store: bit 7 is the mode, bits 6..0 are the codes |
| irq | output | 1 | Error interrupt request |

## Verification
Every stored bit comes out directly on flag_q or code_q, so a wrong next-state shows at the ports on the edge after the stimulus. A lost event, a clear that also hits a written-1 bit, or a lost set-over-clear priority therefore shows within one cycle. A wrong mode decision shows as stale codes surviving, or as codes being dropped, on the very next bus error. A wrong enable or a wrong irq term shows on irq in the same cycle as the flag change.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
   // register map (byte addresses on the host bus)
   localparam int unsigned ERR_ADDR_FLAG = 0;
   localparam int unsigned ERR_ADDR_EN   = 1;
   localparam int unsigned ERR_ADDR_CODE = 2;
   localparam int unsigned ERR_ADDR_TXC  = 3;
   localparam int unsigned ERR_ADDR_RXC  = 4;

   // flag bit positions
   localparam int unsigned FLG_BUS_ERR  = 0;
   localparam int unsigned FLG_WARN     = 1;
   localparam int unsigned FLG_PASSIVE  = 2;
   localparam int unsigned FLG_BOFF_IN  = 3;
   localparam int unsigned FLG_BOFF_OUT = 4;
   localparam int unsigned FLG_OVERRUN  = 5;
   localparam int unsigned FLG_OVLD     = 6;
   localparam int unsigned FLG_LOCK     = 7;

   // code store mode bit position
   localparam int unsigned CODE_MODE_BIT = 7;
endpackage

// File: rtl/can_err_w0c_reg.sv
// Sticky bit register: events set bits, a host write clears bits written 0.
// Set has priority over clear in the same cycle.
module can_err_w0c_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_we,
   input  logic [W-1:0] clr_keep,
   input  logic [W-1:0] set,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_chk_w
      $error("can_err_w0c_reg: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic keep_b;
      assign keep_b = clr_we ? clr_keep[b] : 1'b1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[b] <= 1'b0;
         else        q[b] <= (q[b] & keep_b) | set[b];
      end
   end
endmodule

// File: rtl/can_err_code_store.sv
// Error-code store: a mode bit and CODE_W detail bits.
// Mode 1 accumulates the codes; mode 0 keeps only the latest bus error.
module can_err_code_store #(
   parameter int CODE_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [CODE_W:0] wdata,
   input  logic [CODE_W-1:0] ev_code,
   output logic [CODE_W:0] q,
   output logic            captured
);
   if (CODE_W < 1) begin : g_chk_w
      $error("can_err_code_store: CODE_W must be at least 1");
   end

   logic              mode_q;
   logic [CODE_W-1:0] codes_q;
   logic [CODE_W-1:0] keep;
   logic [CODE_W-1:0] kept;
   logic [CODE_W-1:0] codes_n;
   logic              any_ev;

   assign any_ev = |ev_code;
   assign keep   = wr ? wdata[CODE_W-1:0] : {CODE_W{1'b1}};
   assign kept   = codes_q & keep;

   always_comb begin
      if (!any_ev)     codes_n = kept;
      else if (mode_q) codes_n = kept | ev_code;
      else             codes_n = ev_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         codes_q <= '0;
      end else begin
         if (wr) mode_q <= wdata[CODE_W];
         codes_q <= codes_n;
      end
   end

   assign q        = {mode_q, codes_q};
   assign captured = any_ev;
endmodule

// File: rtl/can_err_regbus.sv
// Byte bus decode and read-back multiplexer.
module can_err_regbus
   import can_err_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] flag_q,
   input  logic [DATA_W-1:0] en_q,
   input  logic [DATA_W-1:0] code_q,
   input  logic [DATA_W-1:0] tx_cnt,
   input  logic [DATA_W-1:0] rx_cnt,
   output logic              we_flag,
   output logic              we_en,
   output logic              we_code,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ERR_ADDR_FLAG);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ERR_ADDR_EN);
   localparam logic [ADDR_W-1:0] A_CODE = ADDR_W'(ERR_ADDR_CODE);
   localparam logic [ADDR_W-1:0] A_TXC  = ADDR_W'(ERR_ADDR_TXC);
   localparam logic [ADDR_W-1:0] A_RXC  = ADDR_W'(ERR_ADDR_RXC);

   assign we_flag = reg_wr && (reg_addr == A_FLAG);
   assign we_en   = reg_wr && (reg_addr == A_EN);
   assign we_code = reg_wr && (reg_addr == A_CODE);

   always_comb begin
      unique case (reg_addr)
         A_FLAG:  rdata = flag_q;
         A_EN:    rdata = en_q;
         A_CODE:  rdata = code_q;
         A_TXC:   rdata = tx_cnt;
         A_RXC:   rdata = rx_cnt;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/can_err_capture.sv
module can_err_capture
   import can_err_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-2:0] ev_status,
   input  logic [DATA_W-2:0] ev_code,
   input  logic [DATA_W-1:0] tx_err_cnt,
   input  logic [DATA_W-1:0] rx_err_cnt,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] flag_q,
   output logic [DATA_W-1:0] code_q,
   output logic              irq
);
   localparam int CODE_W = DATA_W - 1;

   if (DATA_W != 8) begin : g_chk_dw
      $error("can_err_capture: the register layout needs DATA_W == 8");
   end
   if ((1 << ADDR_W) <= ERR_ADDR_RXC) begin : g_chk_aw
      $error("can_err_capture: ADDR_W too small for the register map");
   end

   logic              we_flag, we_en, we_code;
   logic              code_hit;
   logic [DATA_W-1:0] en_q;
   logic [DATA_W-1:0] flag_set;

   can_err_regbus #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
      .reg_wr  (reg_wr),
      .reg_addr(reg_addr),
      .flag_q  (flag_q),
      .en_q    (en_q),
      .code_q  (code_q),
      .tx_cnt  (tx_err_cnt),
      .rx_cnt  (rx_err_cnt),
      .we_flag (we_flag),
      .we_en   (we_en),
      .we_code (we_code),
      .rdata   (reg_rdata)
   );

   can_err_code_store #(.CODE_W(CODE_W)) u_code (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (we_code),
      .wdata   (reg_wdata),
      .ev_code (ev_code),
      .q       (code_q),
      .captured(code_hit)
   );

   assign flag_set = {ev_status, code_hit};

   can_err_w0c_reg #(.W(DATA_W)) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_we  (we_flag),
      .clr_keep(reg_wdata),
      .set     (flag_set),
      .q       (flag_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (we_en) en_q <= reg_wdata;
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_r <= 1'b0;
         else        irq_r <= |(flag_q & en_q);
      end
      assign irq = irq_r;
   end else begin : g_irq_comb
      assign irq = |(flag_q & en_q);
   end
endmodule

// File: rtl/can_err_capture_chk.sv
module can_err_capture_chk
   import can_err_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-2:0] ev_status,
   input logic [DATA_W-2:0] ev_code,
   input logic [DATA_W-1:0] flag_q,
   input logic [DATA_W-1:0] code_q,
   input logic              irq
);
   logic wr_flag, wr_code, wr_ro;
   assign wr_flag = reg_wr && (reg_addr == ADDR_W'(ERR_ADDR_FLAG));
   assign wr_code = reg_wr && (reg_addr == ADDR_W'(ERR_ADDR_CODE));
   assign wr_ro   = reg_wr && (reg_addr >= ADDR_W'(ERR_ADDR_TXC));

   assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_status) |=> ((flag_q[DATA_W-1:1] & $past(ev_status)) == $past(ev_status)));

   assert_code_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_code) |=> flag_q[FLG_BUS_ERR]);

   assert_accum_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q[CODE_MODE_BIT] && !wr_code)
      |=> ((code_q[DATA_W-2:0] & $past(code_q[DATA_W-2:0])) == $past(code_q[DATA_W-2:0])));

   assert_latest_replaces_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((|ev_code) && !code_q[CODE_MODE_BIT]) |=> (code_q[DATA_W-2:0] == $past(ev_code)));

   assert_irq_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|flag_q));

   assert_ro_write_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ro && ev_code == '0) |=> (code_q == $past(code_q)));
endmodule

bind can_err_capture can_err_capture_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .ev_status(ev_status),
   .ev_code  (ev_code),
   .flag_q   (flag_q),
   .code_q   (code_q),
   .irq      (irq)
);

// File: tb/can_err_capture_tb.sv
module can_err_capture_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] ev_status = '0;
   logic [6:0] ev_code = '0;
   logic [7:0] tx_err_cnt = '0;
   logic [7:0] rx_err_cnt = '0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata, flag_q, code_q;
   logic       irq;
   int         n_chk = 0;
   int         n_bad = 0;

   always #5 clk = ~clk;

   can_err_capture u_dut (
      .clk(clk), .rst_n(rst_n), .ev_status(ev_status), .ev_code(ev_code),
      .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .flag_q(flag_q), .code_q(code_q), .irq(irq)
   );

   typedef struct packed {
      logic       wr;
      logic [2:0] addr;
      logic [7:0] wd;
      logic [6:0] st;
      logic [6:0] cd;
      logic [7:0] ef;
      logic [7:0] ec;
      logic       ei;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      {1'b1,3'd1,8'hFF,7'h00,7'h00,8'h00,8'h00,1'b0,4'd10}, // R10 enable all
      {1'b0,3'd0,8'h00,7'h01,7'h00,8'h02,8'h00,1'b1,4'd2},  // R2 warning
      {1'b0,3'd0,8'h00,7'h40,7'h00,8'h82,8'h00,1'b1,4'd2},  // R2 bus lock
      {1'b1,3'd0,8'hFD,7'h00,7'h00,8'h80,8'h00,1'b1,4'd3},  // R3 clear bit 1
      {1'b1,3'd0,8'h7F,7'h40,7'h00,8'h80,8'h00,1'b1,4'd4},  // R4 event beats clear
      {1'b1,3'd0,8'h7F,7'h00,7'h00,8'h00,8'h00,1'b0,4'd3},  // R3 clear bit 7
      {1'b0,3'd0,8'h00,7'h00,7'h08,8'h01,8'h08,1'b1,4'd5},  // R5 CRC code
      {1'b0,3'd0,8'h00,7'h00,7'h01,8'h01,8'h01,1'b1,4'd8},  // R8 stuff replaces
      {1'b1,3'd2,8'hFF,7'h00,7'h00,8'h01,8'h81,1'b1,4'd9},  // R9 set mode
      {1'b0,3'd0,8'h00,7'h00,7'h40,8'h01,8'hC1,1'b1,4'd7},  // R7 ACK delim ORed
      {1'b0,3'd0,8'h00,7'h00,7'h22,8'h01,8'hE3,1'b1,4'd6},  // R6 dominant + form
      {1'b1,3'd2,8'hBE,7'h00,7'h00,8'h01,8'hA2,1'b1,4'd9},  // R9 clear two codes
      {1'b1,3'd0,8'hFE,7'h00,7'h00,8'h00,8'hA2,1'b0,4'd3},  // R3 clear bus error
      {1'b1,3'd1,8'h08,7'h00,7'h00,8'h00,8'hA2,1'b0,4'd10}, // R10 enable bus-off only
      {1'b0,3'd0,8'h00,7'h14,7'h00,8'h28,8'hA2,1'b1,4'd10}, // R10 bus-off + overrun
      {1'b1,3'd0,8'hF7,7'h00,7'h00,8'h20,8'hA2,1'b0,4'd10}, // R10 masked flag left
      {1'b1,3'd3,8'h00,7'h00,7'h00,8'h20,8'hA2,1'b0,4'd12}, // R12 read-only addr
      {1'b1,3'd7,8'h00,7'h00,7'h00,8'h20,8'hA2,1'b0,4'd12}, // R12 unmapped addr
      {1'b1,3'd2,8'h7F,7'h00,7'h00,8'h20,8'h22,1'b0,4'd9},  // R9 mode back to 0
      {1'b0,3'd0,8'h00,7'h00,7'h04,8'h21,8'h04,1'b0,4'd8},  // R8 ACK replaces
      {1'b0,3'd0,8'h00,7'h28,7'h00,8'h71,8'h04,1'b0,4'd2},  // R2 recovery + overload
      {1'b1,3'd2,8'h00,7'h00,7'h02,8'h71,8'h02,1'b0,4'd4}   // R4 code event beats clear
   };

   task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(1, "flags at reset", flag_q, 8'h00);
      chk(1, "code at reset", code_q, 8'h00);
      chk(1, "irq at reset", {7'd0, irq}, 8'h00);
      reg_addr = 3'd1;
      #1 chk(1, "enables at reset", reg_rdata, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         reg_wr    = VEC[i].wr;
         reg_addr  = VEC[i].addr;
         reg_wdata = VEC[i].wd;
         ev_status = VEC[i].st;
         ev_code   = VEC[i].cd;
         @(posedge clk);
         #2;
         chk(int'(VEC[i].req), $sformatf("vector %0d flags", i), flag_q, VEC[i].ef);
         chk(int'(VEC[i].req), $sformatf("vector %0d code", i), code_q, VEC[i].ec);
         chk(int'(VEC[i].req), $sformatf("vector %0d irq", i), {7'd0, irq}, {7'd0, VEC[i].ei});
      end

      @(negedge clk);
      reg_wr = 1'b0; ev_status = '0; ev_code = '0;
      tx_err_cnt = 8'h5A; rx_err_cnt = 8'hA5;
      // R11: read-back of every address
      reg_addr = 3'd0; #1 chk(11, "read flags", reg_rdata, 8'h71);
      reg_addr = 3'd1; #1 chk(11, "read enables", reg_rdata, 8'h08);
      reg_addr = 3'd2; #1 chk(11, "read code", reg_rdata, 8'h02);
      reg_addr = 3'd3; #1 chk(11, "read tx count", reg_rdata, 8'h5A);
      reg_addr = 3'd4; #1 chk(11, "read rx count", reg_rdata, 8'hA5);
      reg_addr = 3'd5; #1 chk(11, "read unmapped", reg_rdata, 8'h00);

      // R10: enabling a set flag raises irq in the same cycle as the enable lands
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h40;
      @(posedge clk); #2;
      chk(10, "irq from overload enable", {7'd0, irq}, 8'h01);
      @(negedge clk);
      reg_wr = 1'b0;

      // R1: reset in mid-run returns everything to 0
      rst_n = 1'b0;
      #1;
      chk(1, "flags after mid reset", flag_q, 8'h00);
      chk(1, "code after mid reset", code_q, 8'h00);
      chk(1, "irq after mid reset", {7'd0, irq}, 8'h00);
      reg_addr = 3'd1;
      #1 chk(1, "enables after mid reset", reg_rdata, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end
endmodule